// File: doc/BRIEF.md
# Timer capture/compare unit

This block sits beside a shared 16-bit free-running count and adds the event logic of a microcontroller timer. It has three input-capture channels and five output-compare channels. A pulse on a capture strobe copies the count into that channel's capture register. A compare channel raises its flag when its register matches the count on a counting tick. This happens only while the channel is enabled. Compare channel 5 can instead act as a fourth capture channel. In that case it uses its own register, its enable bit and its flag bit.

Software reaches the unit through a byte-wide register bus. One write strobe carries an address and data. The read data follows the address without delay. The unit holds an enable mask and a flag register with matching bit positions. Flags clear when 1 is written to them. One interrupt request goes high while any flag is set together with its enable bit. The counter, its prescaler, pin actions and the CPU are outside this block. The `tick_i` input is high during the first clock cycle in which `count_i` shows a new value.

Top module: `tcc_unit`

## Requirements
- R1: Compare channel k (1 to 5) has a 16-bit register. The high byte sits at address 6+2(k-1) and the low byte at address 7+2(k-1). Both bytes are writable and read back what was written.
- R2: A pulse on `cap_stb_i[i-1]` copies `count_i` into capture register i (1 to 3) at the clock edge. The high byte reads at address 2(i-1) and the low byte at 2(i-1)+1. Writes to addresses 0 to 5 are ignored.
- R3: The enable mask sits at address 16 and can be read and written. Bits 7 down to 3 enable compare channels 1 to 5, and bits 2 down to 0 enable capture channels 1 to 3.
- R4: The flag register sits at address 17. Compare channel k sets flag bit 8-k at a clock edge only when three things hold together: `tick_i` is high, `count_i` equals the channel's register, and enable bit 8-k is set. With the enable bit clear, the flag stays clear.
- R5: A count held across cycles with `tick_i` low never sets a compare flag again after it has been cleared.
- R6: A capture on channel i sets flag bit 3-i, whatever the enable mask holds.
- R7: Writing address 17 clears each flag bit written as 1 and leaves bits written as 0 alone. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R8: `irq_o` is high exactly while some flag bit and the enable bit at the same position are both 1.
- R9: While `ch5_cap_sel_i` is high, a pulse on `cap4_stb_i` copies `count_i` into the compare 5 register (addresses 14 and 15) and sets flag bit 3. In this mode, channel 5 matches set no flag.
- R10: Reset clears the flags, the enables, and the capture and compare registers. Addresses 18 to 31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 16 | Shared free-running count |
| tick_i | input | 1 | High in the first cycle of a new count value |
| cap_stb_i | input | 3 | Capture strobes, bit i-1 for channel i |
| ch5_cap_sel_i | input | 1 | Makes channel 5 work as a capture channel |
| cap4_stb_i | input | 1 | Strobe for the fourth capture function |
| bus_addr_i | input | 5 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets these corner cases:
- **Clearing a flag while the count holds at a matching value.** A design that compared on every cycle instead of on ticks would set the flag again at once.
- **A set and a clear of one flag bit in the same cycle.** A design with the wrong priority would drop a capture event.
- **A compare that passes while its channel is disabled.** A design that left out the enable gate would raise a flag that software never asked for.
- **Channel 5 switched into capture mode.** The bench checks that the captured count lands in the compare 5 register. It also checks that a later count equal to that value sets no flag.
- **Writes to the capture addresses.** The bench checks that these writes leave the captured values untouched.

Beyond these cases, a long randomized run follows every cycle to catch stray differences in read data or in the interrupt request.

// File: rtl/tcc_unit.sv
`timescale 1ns/1ps
module tcc_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] count_i,
  input  logic        tick_i,
  input  logic [2:0]  cap_stb_i,
  input  logic        ch5_cap_sel_i,
  input  logic        cap4_stb_i,
  input  logic [4:0]  bus_addr_i,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  output logic        irq_o
);
  localparam int NCAP = 3;
  localparam int NCMP = 5;
  localparam logic [4:0] A_CMP = 5'd6;
  localparam logic [4:0] A_EN  = 5'd16;
  localparam logic [4:0] A_FLG = 5'd17;

  logic [15:0] cap_q [NCAP];
  logic [15:0] cmp_q [NCMP];
  logic [7:0]  en_q, flg_q, set_v, clr_v;
  logic        cap4_hit;

  assign cap4_hit = ch5_cap_sel_i && cap4_stb_i;
  assign clr_v = (bus_we_i && bus_addr_i == A_FLG) ? bus_wdata_i : 8'h00;
  assign irq_o = |(flg_q & en_q);

  always_comb begin
    set_v = 8'h00;
    for (int k = 0; k < NCMP; k++)
      if (tick_i && count_i == cmp_q[k] && en_q[7-k] && !(k == NCMP-1 && ch5_cap_sel_i))
        set_v[7-k] = 1'b1;
    for (int i = 0; i < NCAP; i++)
      if (cap_stb_i[i]) set_v[2-i] = 1'b1;
    if (cap4_hit) set_v[3] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flg_q <= 8'h00;
      en_q  <= 8'h00;
    end else begin
      flg_q <= (flg_q & ~clr_v) | set_v;
      if (bus_we_i && bus_addr_i == A_EN) en_q <= bus_wdata_i;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NCAP; i++) cap_q[i] <= 16'h0000;
    end else begin
      for (int i = 0; i < NCAP; i++)
        if (cap_stb_i[i]) cap_q[i] <= count_i;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < NCMP; k++) cmp_q[k] <= 16'h0000;
    end else begin
      for (int k = 0; k < NCMP; k++) begin
        if (k == NCMP-1 && cap4_hit)
          cmp_q[k] <= count_i;
        else if (bus_we_i && bus_addr_i == A_CMP + 5'(2*k))
          cmp_q[k][15:8] <= bus_wdata_i;
        else if (bus_we_i && bus_addr_i == A_CMP + 5'(2*k+1))
          cmp_q[k][7:0] <= bus_wdata_i;
      end
    end

  always_comb begin
    bus_rdata_o = 8'h00;
    if (bus_addr_i < A_CMP)
      bus_rdata_o = bus_addr_i[0] ? cap_q[bus_addr_i[2:1]][7:0] : cap_q[bus_addr_i[2:1]][15:8];
    else if (bus_addr_i < A_EN) begin
      for (int k = 0; k < NCMP; k++) begin
        if (bus_addr_i == A_CMP + 5'(2*k))   bus_rdata_o = cmp_q[k][15:8];
        if (bus_addr_i == A_CMP + 5'(2*k+1)) bus_rdata_o = cmp_q[k][7:0];
      end
    end
    else if (bus_addr_i == A_EN)  bus_rdata_o = en_q;
    else if (bus_addr_i == A_FLG) bus_rdata_o = flg_q;
  end
endmodule

module tcc_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic [2:0] cap_stb_i,
  input logic       ch5_cap_sel_i,
  input logic       cap4_stb_i,
  input logic [4:0] bus_addr_i,
  input logic       bus_we_i,
  input logic [7:0] bus_wdata_i,
  input logic [7:0] en_q,
  input logic [7:0] flg_q,
  input logic       irq_o
);
  p_en_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we_i && bus_addr_i == 5'd16 |=> en_q == $past(bus_wdata_i));
  p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[7]) |-> $past(tick_i) && $past(en_q[7]));
  p_cap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb_i[0] |=> flg_q[2]);
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we_i && bus_addr_i == 5'd17 && bus_wdata_i[6] && !tick_i |=> !flg_q[6]);
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !bus_we_i |=> irq_o);
  p_cap4_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[3]) && $past(ch5_cap_sel_i) |-> $past(cap4_stb_i));
endmodule

bind tcc_unit tcc_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cap_stb_i(cap_stb_i),
  .ch5_cap_sel_i(ch5_cap_sel_i), .cap4_stb_i(cap4_stb_i),
  .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
  .en_q(en_q), .flg_q(flg_q), .irq_o(irq_o)
);

// File: tb/test_tcc_unit.sv
`timescale 1ns/1ps
module test_tcc_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] count = 16'h0;
  logic tick = 1'b0, ch5sel = 1'b0, cap4 = 1'b0, we = 1'b0;
  logic [2:0] stb = 3'b000;
  logic [4:0] addr = 5'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit run = 0, ph = 0, done = 0;

  int m_cap [3];
  int m_cmp [5];
  int m_en, m_flg;

  always #4 clk = ~clk;

  tcc_unit i_tcc_unit (
    .clk(clk), .rst_n(rst_n), .count_i(count), .tick_i(tick), .cap_stb_i(stb),
    .ch5_cap_sel_i(ch5sel), .cap4_stb_i(cap4), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    int set, clr;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) m_cap[i] = 0;
      for (int k = 0; k < 5; k++) m_cmp[k] = 0;
      m_en = 0; m_flg = 0;
    end else begin
      set = 0; clr = 0;
      for (int k = 0; k < 5; k++)
        if (tick && int'(count) == m_cmp[k] && m_en[7-k] && !(k == 4 && ch5sel)) set |= 1 << (7-k);
      for (int i = 0; i < 3; i++)
        if (stb[i]) begin m_cap[i] = int'(count); set |= 1 << (2-i); end
      if (we) begin
        if (addr >= 6 && addr <= 15) begin
          if (addr % 2 == 0) m_cmp[(addr-6)/2] = (m_cmp[(addr-6)/2] & 32'hFF) | (int'(wdata) << 8);
          else m_cmp[(addr-6)/2] = (m_cmp[(addr-6)/2] & 32'hFF00) | int'(wdata);
        end
        if (addr == 16) m_en = int'(wdata);
        if (addr == 17) clr = int'(wdata);
      end
      if (ch5sel && cap4) begin m_cmp[4] = int'(count); set |= 8; end
      m_flg = (m_flg & ~clr) | set;
    end
  end

  function automatic int model_rd(int a);
    if (a < 6) return a % 2 ? m_cap[a/2] & 255 : (m_cap[a/2] >> 8) & 255;
    if (a < 16) return a % 2 ? m_cmp[(a-6)/2] & 255 : (m_cmp[(a-6)/2] >> 8) & 255;
    if (a == 16) return m_en;
    if (a == 17) return m_flg;
    return 0;
  endfunction

  function automatic string tag_of(int a);
    if (a < 6) return "R2";
    if (a < 16) return "R1";
    if (a == 16) return "R3";
    if (a == 17) return "R7";
    return "R10";
  endfunction

  initial forever begin
    @(negedge clk); #2;
    if (rst_n && !done) begin
      checks++;
      if (int'(rdata) != model_rd(int'(addr))) begin
        fails++;
        $display("FAIL %s model rdata addr %0d actual %h expected %h", tag_of(int'(addr)), addr, rdata, model_rd(int'(addr)));
      end
      checks++;
      if (irq != ((m_flg & m_en) != 0)) begin
        fails++;
        $display("FAIL R8 model irq actual %0b expected %0b", irq, (m_flg & m_en) != 0);
      end
    end
  end

  task automatic next();
    @(negedge clk);
    we = 1'b0; stb = 3'b000; cap4 = 1'b0;
    if (run) begin
      ph = !ph;
      if (ph) begin count = count + 16'd1; tick = 1'b1; end else tick = 1'b0;
    end else tick = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    next(); addr = a; we = 1'b1; wdata = d;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    next(); addr = a; #2;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s read addr %0d actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    next(); #2;
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) next();
    rst_n = 1'b1;
    next();
    // R10: reset state and unmapped addresses
    for (int a = 0; a < 32; a++) rd(5'(a), 8'h00, "R10");
    chk_irq(1'b0, "R10");
    // R1: compare registers write and read back
    for (int k = 0; k < 5; k++) begin
      wr(5'(6+2*k), 8'(8'h11*(k+1)));
      wr(5'(7+2*k), 8'h00);
    end
    for (int k = 0; k < 5; k++) begin
      rd(5'(6+2*k), 8'(8'h11*(k+1)), "R1");
      rd(5'(7+2*k), 8'h00, "R1");
    end
    // R2: capture address writes ignored
    wr(5'd0, 8'hAA); wr(5'd5, 8'h55);
    rd(5'd0, 8'h00, "R2"); rd(5'd5, 8'h00, "R2");
    // R3
    wr(5'd16, 8'hF8);
    rd(5'd16, 8'hF8, "R3");
    // R4: enabled match of channel 1 (0x1100)
    next(); count = 16'h10FD; run = 1;
    repeat (14) next();
    run = 0;
    rd(5'd17, 8'h80, "R4");
    chk_irq(1'b1, "R8");
    // R4: disabled channel passes its value
    wr(5'd16, 8'h78); wr(5'd17, 8'hFF);
    next(); count = 16'h10FD; run = 1;
    repeat (14) next();
    run = 0;
    rd(5'd17, 8'h00, "R4");
    chk_irq(1'b0, "R8");
    // R5: single tick on match, then count held
    wr(5'd16, 8'hF8);
    next(); count = 16'h2200; tick = 1'b1;
    rd(5'd17, 8'h40, "R5");
    wr(5'd17, 8'h40);
    repeat (10) next();
    rd(5'd17, 8'h00, "R5");
    // R6: captures set flags regardless of enable
    wr(5'd16, 8'h00);
    next(); count = 16'h1234; stb = 3'b111;
    rd(5'd0, 8'h12, "R2"); rd(5'd1, 8'h34, "R2");
    rd(5'd2, 8'h12, "R2"); rd(5'd5, 8'h34, "R2");
    wr(5'd2, 8'h99);
    rd(5'd2, 8'h12, "R2");
    rd(5'd17, 8'h07, "R6");
    chk_irq(1'b0, "R8");
    wr(5'd16, 8'h01);
    chk_irq(1'b1, "R8");
    // R7: partial clear, then set and clear together
    wr(5'd17, 8'h05);
    rd(5'd17, 8'h02, "R7");
    next(); count = 16'h0777; stb = 3'b010; addr = 5'd17; we = 1'b1; wdata = 8'h02;
    rd(5'd17, 8'h02, "R7");
    rd(5'd3, 8'h77, "R2");
    // R9: channel 5 as fourth capture
    wr(5'd17, 8'hFF);
    next(); ch5sel = 1'b1; count = 16'h4321;
    wr(5'd16, 8'h08);
    next(); cap4 = 1'b1;
    rd(5'd14, 8'h43, "R9"); rd(5'd15, 8'h21, "R9");
    rd(5'd17, 8'h08, "R9");
    wr(5'd17, 8'hFF);
    next(); tick = 1'b1;
    rd(5'd17, 8'h00, "R9");
    // R10: reset mid-run
    next(); rst_n = 1'b0; ch5sel = 1'b0;
    next(); rst_n = 1'b1;
    rd(5'd16, 8'h00, "R10"); rd(5'd14, 8'h00, "R10"); rd(5'd0, 8'h00, "R10");
    // randomized run against the model
    run = 1;
    for (int n = 0; n < 3000; n++) begin
      next();
      ch5sel = (n / 500) % 2 == 1;
      addr = 5'($urandom % 20);
      if ($urandom % 4 == 0) begin
        we = 1'b1;
        wdata = ($urandom % 2) ? (addr % 2 ? 8'(count[7:0] + 8'd6) : count[15:8]) : 8'($urandom);
      end
      if ($urandom % 16 == 0) stb = 3'($urandom);
      if ($urandom % 32 == 0) cap4 = 1'b1;
    end
    run = 0;
    next();
    finish_run();
  end
endmodule